// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the bus-facing engine of a 256-byte nonvolatile memory model that sits on a two-wire serial bus. A fast system clock oversamples the bus clock and data lines. The block finds start and stop conditions and decodes the control byte against a fixed device code and three strap inputs. It acknowledges correctly addressed transfers and keeps the single address pointer that all read and write transfers share. The block drives the data line only by pulling it low, through an output-enable.

Bytes that the master writes are handed one at a time to a separate page-write block, each tagged with its target address. A one-cycle stop strobe then tells that block to begin its self-timed programming cycle. While the programming cycle runs, the page-write block holds `wr_busy` high. During that time the engine refuses to acknowledge, so a master can poll the part by sending control bytes until one is acknowledged. Reads fetch bytes combinationally from the memory model through `mem_addr` and `mem_rdata`.

Top module: `eeprom_bus_slave`

## Requirements
- R1: After reset, and after any stop condition (SDA rising while SCL is high), the engine is idle with `sda_oe` low and ignores the bus until a start condition (SDA falling while SCL is high). The address pointer resets to 00h.
- R2: The first byte after a start is the control byte, received MSB first. It is acknowledged only if bits 7:4 equal 1010 and bits 3:1 equal `dev_sel[2]`, `dev_sel[1]` and `dev_sel[0]` in that order. Bit 0 selects a read (1) or a write (0).
- R3: An acknowledge asserts `sda_oe` from the SCL falling edge that ends the eighth bit until the falling edge that ends the ninth, so SDA stays low for the whole ninth high period.
- R4: When the control byte does not match, the engine never drives SDA before the next start or stop.
- R5: In a write transfer, the byte that follows the control byte is acknowledged and loaded into the address pointer.
- R6: Each later write byte is acknowledged and appears once on `wr_byte_stb`, with `wr_addr` equal to the pointer and `wr_data` equal to the byte. The pointer then advances within its aligned 16-byte page: the low four bits wrap and the upper bits are kept.
- R7: A read control byte is acknowledged, and the byte at the current pointer is then sent MSB first. A current-address read therefore returns the byte after the last one accessed.
- R8: A random read sets the pointer with an address-only write transfer, then uses a repeated start and a read control byte. It returns the byte at that address.
- R9: If the master acknowledges a sent byte (SDA low on the ninth clock), the engine sends the next byte. If the master does not acknowledge, SDA stays released until the next start or stop.
- R10: The pointer increments after each byte sent and rolls over from FFh to 00h.
- R11: If `wr_busy` is high when a control byte completes, no acknowledge is given, even when the control byte matches.
- R12: `wr_stop_stb` pulses for one cycle on a stop condition, and only when at least one data byte was handed over since the latest start. Address-only transfers and read transfers give no pulse.
- R13: `sda_oe` changes only in the cycle after a synchronised SCL falling edge, start or stop. It never changes in the middle of an SCL high period.
- R14: A start in the middle of a byte aborts the transfer and restarts control-byte reception. A stop in the middle of a byte discards the partial byte: no strobe is given and the pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| dev_sel | input | 3 | Chip-select straps compared with control bits 3:1 |
| wr_busy | input | 1 | Programming cycle in progress |
| mem_addr | output | 8 | Read address (the pointer) into the memory model |
| mem_rdata | input | 8 | Byte at `mem_addr` |
| wr_byte_stb | output | 1 | One-cycle pulse per received write data byte |
| wr_addr | output | 8 | Target address for the strobed byte |
| wr_data | output | 8 | Strobed write data byte |
| wr_stop_stb | output | 1 | One-cycle pulse that starts the programming cycle |

## Verification
The bench targets the page wrap at 1Fh→10h; a design that carried into the upper bits would write the next page. It reads across FFh→00h, where a pointer that saturated or widened would return the wrong byte. It polls with a matching control byte during the programming cycle; a design that checked only the address match would acknowledge there. It also aborts transfers mid-byte with a start and with a stop; a design that kept stale bit counts would misframe the next control byte, or would emit a spurious write strobe and lose the pointer.

// File: rtl/eeprom_slv_pkg.sv
package eeprom_slv_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_CODE) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync
    import eeprom_slv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] scl_sr, sda_sr;
    logic         scl_q, sda_q;
    logic         scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[MSB-1:0], scl_i};
            sda_sr <= {sda_sr[MSB-1:0], sda_i};
            scl_q  <= scl_sr[MSB];
            sda_q  <= sda_sr[MSB];
        end
    end

    assign scl_s = scl_sr[MSB];
    assign sda_s = sda_sr[MSB];

    always_comb begin
        evt.scl   = scl_s;
        evt.sda   = sda_s;
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/addr_ptr.sv
module addr_ptr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_seq,
    input  logic              inc_page,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc_seq) begin
            ptr <= ptr + ONE;
        end else if (inc_page) begin
            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
        end
    end

    // write bytes never leave the current page
    p_page_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (inc_page && !load) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/proto_fsm.sv
module proto_fsm
    import eeprom_slv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [2:0]        dev_sel,
    input  logic              wr_busy,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] ptr,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] ptr_load_val,
    output logic              ptr_inc_seq,
    output logic              ptr_inc_page,
    output logic              sda_oe,
    output logic              wr_byte_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_stop_stb
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    slv_state_e        state, after;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              oe_q, got_data, mack_ok;
    logic              quiet, byte_end;

    assign quiet    = !evt.start && !evt.stop;
    assign byte_end = quiet && evt.fall && (cnt == FULL);

    assign ptr_load     = (state == ST_ADDR) && byte_end;
    assign ptr_load_val = ADDR_W'(shreg);
    assign ptr_inc_page = (state == ST_WDATA) && byte_end;
    assign ptr_inc_seq  = (state == ST_TX) && byte_end;
    assign sda_oe       = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            after       <= ST_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            oe_q        <= 1'b0;
            got_data    <= 1'b0;
            mack_ok     <= 1'b0;
            wr_byte_stb <= 1'b0;
            wr_stop_stb <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            wr_byte_stb <= 1'b0;
            wr_stop_stb <= 1'b0;
            if (evt.stop) begin
                wr_stop_stb <= got_data;
                got_data    <= 1'b0;
                oe_q        <= 1'b0;
                state       <= ST_IDLE;
            end else if (evt.start) begin
                got_data <= 1'b0;
                oe_q     <= 1'b0;
                cnt      <= '0;
                state    <= ST_CTRL;
            end else begin
                unique case (state)
                    ST_CTRL, ST_ADDR, ST_WDATA: begin
                        if (evt.rise) begin
                            shreg <= {shreg[DATA_W-2:0], evt.sda};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (byte_end) begin
                            cnt <= '0;
                            if (state == ST_CTRL) begin
                                if (ctrl_hit(shreg[7:0], dev_sel) && !wr_busy) begin
                                    oe_q  <= 1'b1;
                                    after <= shreg[0] ? ST_TX : ST_ADDR;
                                    state <= ST_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                oe_q  <= 1'b1;
                                after <= ST_WDATA;
                                state <= ST_ACK;
                                if (state == ST_WDATA) begin
                                    wr_byte_stb <= 1'b1;
                                    wr_addr     <= ptr;
                                    wr_data     <= shreg;
                                    got_data    <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.fall) begin
                            if (after == ST_TX) begin
                                shreg <= mem_rdata;
                                oe_q  <= ~mem_rdata[DATA_W-1];
                                cnt   <= CNT_W'(1);
                            end else begin
                                oe_q <= 1'b0;
                                cnt  <= '0;
                            end
                            state <= after;
                        end
                    end
                    ST_TX: begin
                        if (evt.fall) begin
                            if (cnt == FULL) begin
                                oe_q  <= 1'b0;
                                state <= ST_MACK;
                            end else begin
                                oe_q  <= ~shreg[DATA_W-2];
                                shreg <= {shreg[DATA_W-2:0], 1'b0};
                                cnt   <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.rise) begin
                            mack_ok <= ~evt.sda;
                        end else if (evt.fall) begin
                            if (mack_ok) begin
                                shreg <= mem_rdata;
                                oe_q  <= ~mem_rdata[DATA_W-1];
                                cnt   <= CNT_W'(1);
                                state <= ST_TX;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_stop_idle_r1: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !oe_q));

    p_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && !evt.fall && quiet) |=> oe_q);

    p_ignore_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !oe_q);

    p_byte_src_r6: assert property (@(posedge clk) disable iff (rst)
        wr_byte_stb |-> ($past(state) == ST_WDATA));

    p_busy_no_ack_r11: assert property (@(posedge clk) disable iff (rst)
        ($rose(oe_q) && $past(state) == ST_CTRL) |-> !$past(wr_busy));

    p_stop_stb_r12: assert property (@(posedge clk) disable iff (rst)
        wr_stop_stb |-> $past(evt.stop));

    p_oe_on_edge_r13: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> $past(evt.fall || evt.start || evt.stop));

    p_start_ctrl_r14: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_CTRL && cnt == '0));

endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
    import eeprom_slv_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        dev_sel,
    input  logic              wr_busy,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_byte_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_stop_stb
);
    bus_evt_t          evt;
    logic [ADDR_W-1:0] ptr, ptr_load_val;
    logic              ptr_load, ptr_inc_seq, ptr_inc_page;

    bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .inc_seq  (ptr_inc_seq),
        .inc_page (ptr_inc_page),
        .ptr      (ptr)
    );

    proto_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .dev_sel      (dev_sel),
        .wr_busy      (wr_busy),
        .mem_rdata    (mem_rdata),
        .ptr          (ptr),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_inc_seq  (ptr_inc_seq),
        .ptr_inc_page (ptr_inc_page),
        .sda_oe       (sda_oe),
        .wr_byte_stb  (wr_byte_stb),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_stop_stb  (wr_stop_stb)
    );

    assign mem_addr = ptr;

endmodule

// File: tb/test_eeprom_bus_slave.sv
module test_eeprom_bus_slave;
    localparam int H        = 12;
    localparam int BUSY_CYC = 400;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_line, sda_oe, wr_busy;
    logic [7:0] mem_addr, mem_rdata, wr_addr, wr_data;
    logic       wr_byte_stb, wr_stop_stb;
    logic [7:0] dev_mem [256];
    logic [7:0] ref_mem [256];
    logic [15:0] exp_q[$];
    logic [15:0] pend_q[$];
    int n_chk = 0, n_err = 0, cyc = 0, busy_cnt = 0, stops = 0, exp_stops = 0;
    int scl_hi = 0;
    logic prev_oe = 1'b0;
    int exp_ptr = 0;

    assign sda_line  = sda_m & ~sda_oe;
    assign mem_rdata = dev_mem[mem_addr];
    assign wr_busy   = (busy_cnt != 0);

    eeprom_bus_slave i_eeprom_bus_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .dev_sel(STRAP), .wr_busy(wr_busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_byte_stb(wr_byte_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_stop_stb(wr_stop_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // per-clock reference model: page-write block, strobe checks, SDA stability
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog", cyc, 150000);
            finish_run();
        end
        if (busy_cnt != 0) busy_cnt--;
        if (!rst) begin
            if (wr_byte_stb) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6/R14 unexpected byte strobe", {wr_addr, wr_data}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk({wr_addr, wr_data} == e, "R6 byte strobe addr/data", {wr_addr, wr_data}, e);
                end
                pend_q.push_back({wr_addr, wr_data});
            end
            if (wr_stop_stb) begin
                stops++;
                while (pend_q.size() != 0) begin
                    logic [15:0] p;
                    p = pend_q.pop_front();
                    dev_mem[p[15:8]] = p[7:0];
                end
                busy_cnt = BUSY_CYC;
            end
            if (scl_hi > 6 && sda_oe != prev_oe)
                chk(0, "R13 sda_oe changed during SCL high", sda_oe, prev_oe);
        end
        scl_hi  = scl_m ? scl_hi + 1 : 0;
        prev_oe = sda_oe;
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(H);
        scl_m = 1'b1; w(H);
        sda_m = 1'b0; w(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(H);
        scl_m = 1'b1; w(H);
        sda_m = 1'b1; w(2 * H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; w(H);
            scl_m = 1'b1; w(H);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked, output bit held);
        logic a0, a1, a2;
        send_bits(b, 8);
        sda_m = 1'b1; w(H);
        scl_m = 1'b1; w(1);
        a0 = sda_line; w(H / 2 - 1);
        a1 = sda_line; w(H / 2 - 1);
        a2 = sda_line; w(1);
        scl_m = 1'b0;
        acked = !a0 && !a1 && !a2;
        held  = (a0 == a1) && (a1 == a2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b, output bit rel);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(H);
            scl_m = 1'b1; w(H / 2);
            b[i] = sda_line; w(H / 2);
            scl_m = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; w(H);
        scl_m = 1'b1; w(H / 2);
        rel = !sda_oe; w(H / 2);
        scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic expect_ack(input logic [7:0] b, input string tag);
        bit a, h;
        send_byte(b, a, h);
        chk(a, tag, a, 1);
        chk(h, "R3 ack held over ninth high", h, 1);
    endtask

    task automatic expect_nack(input logic [7:0] b, input string tag);
        bit a, h;
        send_byte(b, a, h);
        chk(!a, tag, a, 0);
    endtask

    task automatic read_bytes(input int n, input string tag);
        logic [7:0] d;
        bit rel;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d, rel);
            chk(d == ref_mem[exp_ptr], tag, d, ref_mem[exp_ptr]);
            if (k == n - 1) chk(rel, "R9 SDA released at master no-ack", rel, 1);
            exp_ptr = (exp_ptr + 1) % 256;
        end
    endtask

    task automatic write_seq(input int addr, input int n, input int seed);
        int a;
        bus_start();
        expect_ack(CW, "R2 write control ack");
        expect_ack(8'(addr), "R5 word address ack");
        a = addr;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'(seed + 37 * k);
            exp_q.push_back({8'(a), d});
            ref_mem[a] = d;
            expect_ack(d, "R6 data byte ack");
            a = (a & 8'hF0) | ((a + 1) & 8'h0F);
        end
        bus_stop();
        exp_stops++;
        exp_ptr = a;
    endtask

    task automatic wait_idle();
        w(2);
        while (busy_cnt != 0) w(1);
        w(4);
    endtask

    task automatic random_read(input int addr, input int n, input string tag);
        bus_start();
        expect_ack(CW, "R8 write control ack");
        expect_ack(8'(addr), "R8 address ack");
        exp_ptr = addr;
        bus_start();
        expect_ack(CR, "R8 read control ack");
        read_bytes(n, tag);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = 8'(i * 13 + 5);
            ref_mem[i] = 8'(i * 13 + 5);
        end
        rst = 1'b1;
        w(5);
        rst = 1'b0;
        w(2);
        chk(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);
        chk(mem_addr == 8'h00, "R1 pointer 00h after reset", mem_addr, 0);
        chk(!wr_byte_stb && !wr_stop_stb, "R1 no strobes after reset", wr_byte_stb, 0);

        // wrong device code and wrong strap
        bus_start(); expect_nack(8'h9A, "R2/R4 wrong code no ack"); bus_stop();
        bus_start(); expect_nack({4'b1010, 3'b100, 1'b0}, "R2/R4 wrong strap no ack"); bus_stop();

        // plain write, then polling while busy
        write_seq(8'h10, 3, 8'h21);
        bus_start(); expect_nack(CW, "R11 no ack while busy"); bus_stop();
        wait_idle();
        chk(stops == exp_stops, "R12 stop strobe after write", stops, exp_stops);

        // current address read
        bus_start(); expect_ack(CR, "R7 read control ack");
        read_bytes(1, "R7 current address read data"); bus_stop();

        // random + sequential read over written bytes
        random_read(8'h10, 3, "R9 sequential read data");
        chk(stops == exp_stops, "R12 no stop strobe for address-only/read", stops, exp_stops);

        // page wrap
        write_seq(8'h1E, 3, 8'h5C);
        wait_idle();
        random_read(8'h10, 1, "R6 page wrap stored at 10h");
        random_read(8'h1E, 2, "R6 bytes before wrap");

        // rollover FFh -> 00h
        random_read(8'hFE, 3, "R10 rollover read");
        bus_start(); expect_ack(CR, "R10 read control after rollover");
        read_bytes(1, "R10 pointer continues at 01h"); bus_stop();

        // mid-byte stop discards partial data and keeps pointer
        bus_start();
        expect_ack(CW, "R14 write control ack");
        expect_ack(8'h40, "R14 address ack");
        send_bits(8'hFF, 3);
        bus_stop();
        exp_ptr = 8'h40;
        w(10);
        chk(stops == exp_stops, "R14 no stop strobe after partial byte", stops, exp_stops);
        bus_start(); expect_ack(CR, "R14 read after aborted write");
        read_bytes(1, "R14 pointer kept at 40h"); bus_stop();

        // mid-byte start restarts control reception
        bus_start();
        send_bits(CR, 4);
        bus_start();
        expect_ack(CR, "R14 control after mid-byte start");
        read_bytes(1, "R14 read data after restart"); bus_stop();

        w(20);
        chk(exp_q.size() == 0, "R6 all expected byte strobes seen", exp_q.size(), 0);
        chk(stops == exp_stops, "R12 total stop strobes", stops, exp_stops);
        finish_run();
    end

endmodule